// File: doc/BRIEF.md
# Packed Lane Funnel Shifter

This block is a SIMD execution slice that works on a 512-bit vector. The vector is cut into lanes of 16, 32 or 64 bits. In every lane it joins two values into one double-width value. The lane of the second source forms the upper half and the matching lane of the current destination forms the lower half. It shifts that value right logically by a count taken from the same lane of a count vector, and keeps the low lane-width bits as the new destination lane. The count can also come from element 0 of the count vector for every lane. Three things limit what reaches the output: a per-lane write mask, with merge or zeroing behaviour, a selected vector length, and a rule that clears every bit above that length.

The destination is both an operand and the result. The block therefore samples the old destination, the second source and the counts on a one-cycle valid pulse. It computes all lanes combinationally and registers the finished vector, which appears together with a valid flag on the following cycle. Instruction decode, operand fetch and fault handling are the job of the surrounding pipeline.

Top module: `lane_funnel_shifter`

## Requirements
- R1: For each active lane of width W, the result lane equals the low W bits of ({second-source lane, old destination lane} >> count).
- R2: Only the low bits of each count are used: count & 15 for 16-bit lanes, count & 31 for 32-bit lanes and count & 63 for 64-bit lanes. Lane j's count sits in bits [j*W +: W] of cntIn.
- R3: elemSel encodes the lane width: 0 = 16, 1 = 32, 2 or 3 = 64. lenSel encodes the vector length: 0 = 128, 1 = 256, 2 or 3 = 512. Every output bit at or above the selected length is zero, whatever the mask says.
- R4: A lane takes the shifted result when maskEn is 0, or when its mask bit maskIn[j] is 1.
- R5: With maskEn = 1 and zeroMode = 1, a lane whose mask bit is 0 becomes zero.
- R6: With maskEn = 1 and zeroMode = 0, a lane whose mask bit is 0 keeps the old destination lane.
- R7: With bcast = 1 and 32- or 64-bit lanes, every lane uses element 0 of cntIn (bits [W-1:0]) as its count.
- R8: With 16-bit lanes, bcast has no effect and each lane uses its own count.
- R9: Mask bits at or above the active lane count have no effect on the output.
- R10: A masked count of 0 returns the old destination lane. A masked count of W-1 puts the top bit of the destination lane in bit 0 and fills the rest from the low W-1 bits of the second-source lane.
- R11: On a cycle where validIn is 1, the block captures the result, and one cycle later validOut is 1. On a cycle where validIn is 0, validOut is 0 on the next cycle and dstOut holds its value.
- R12: An active-low reset clears dstOut and validOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operands valid; capture the result this cycle |
| elemSel | input | 2 | Lane width select (0:16, 1:32, 2/3:64) |
| lenSel | input | 2 | Vector length select (0:128, 1:256, 2/3:512) |
| maskEn | input | 1 | Apply the write mask |
| zeroMode | input | 1 | 1: clear masked-off lanes; 0: keep them |
| bcast | input | 1 | Use count element 0 for every lane (32/64-bit lanes only) |
| maskIn | input | 32 | Per-lane write mask, bit j for lane j |
| dstIn | input | 512 | Old destination vector (low half of each pair) |
| srcIn | input | 512 | Second source vector (high half of each pair) |
| cntIn | input | 512 | Per-lane shift counts |
| validOut | output | 1 | Result valid |
| dstOut | output | 512 | New destination vector |

## Verification
The hardest case to reach is a mix of conditions that each hide a different part of the datapath. These include a short vector length with mask bits set above the active lanes, broadcast requested with 16-bit lanes, and counts whose upper bits are set but masked away. Random operands, counts and masks alone seldom land on these. The stimulus therefore sweeps every combination of lane width, vector length and masking mode with random data. It also adds directed operations with hand-worked values: counts of 0 and of the lane width minus one, a count with bits above the mask, broadcast with a differing per-lane count, and an all-ones mask on a 128-bit vector. A behavioural model in the bench is compared against the outputs on every clock.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam int VEC_W       = 512;
  localparam int CHUNK_W     = 16;
  localparam int NUM_CHUNKS  = VEC_W / CHUNK_W;
  localparam int CHUNK_IDX_W = $clog2(NUM_CHUNKS);
  localparam int MASK_W      = NUM_CHUNKS;
  localparam int MIN_VEC_W   = 128;
  localparam int MIN_CHUNKS  = MIN_VEC_W / CHUNK_W;
  localparam int NUM_SIZES   = 3;

  typedef enum logic [1:0] {
    SIZE_16 = 2'd0,
    SIZE_32 = 2'd1,
    SIZE_64 = 2'd2
  } laneSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;
    logic [NUM_CHUNKS-1:0] inRange;
    logic [NUM_CHUNKS-1:0] takeShift;
    logic [NUM_CHUNKS-1:0] forceZero;
    laneSize_e             sizeSel;
    logic                  useBcast;
  } strobe_t;

endpackage

// File: rtl/lfs_lane_shift.sv
module lfs_lane_shift #(
  parameter int LANE_W = 16,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] hiIn,
  input  logic [LANE_W-1:0] loIn,
  input  logic [AMT_W-1:0]  amt,
  output logic [LANE_W-1:0] res
);

  // funnel: low bits come from loIn, vacated top bits from hiIn
  logic [AMT_W:0] backAmt;

  assign backAmt = (AMT_W+1)'(LANE_W) - {1'b0, amt};
  assign res     = (loIn >> amt) | (hiIn << backAmt);

endmodule

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [1:0]        elemSel,
  input  logic [1:0]        lenSel,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic              bcast,
  input  logic [MASK_W-1:0] maskIn,
  output strobe_t           strb,
  output logic              validOut
);

  laneSize_e            sizeCode;
  logic [1:0]           lenCode;
  logic [CHUNK_IDX_W:0] activeChunks;

  always_comb begin
    case (elemSel)
      2'd0:    sizeCode = SIZE_16;
      2'd1:    sizeCode = SIZE_32;
      default: sizeCode = SIZE_64;
    endcase
  end

  assign lenCode      = (lenSel == 2'd3) ? 2'd2 : lenSel;
  assign activeChunks = (CHUNK_IDX_W+1)'(MIN_CHUNKS) << lenCode;

  logic [NUM_CHUNKS-1:0] inRangeVec;
  logic [NUM_CHUNKS-1:0] takeVec;
  logic [NUM_CHUNKS-1:0] zeroVec;

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic [CHUNK_IDX_W-1:0] laneIdx;
    logic                   laneBit;
    assign laneIdx       = CHUNK_IDX_W'(c) >> sizeCode;
    assign laneBit       = maskIn[laneIdx];
    assign inRangeVec[c] = (CHUNK_IDX_W+1)'(c) < activeChunks;
    assign takeVec[c]    = !maskEn || laneBit;
    assign zeroVec[c]    = maskEn && !laneBit && zeroMode;
  end

  always_comb begin
    strb.load      = validIn;
    strb.inRange   = inRangeVec;
    strb.takeShift = takeVec;
    strb.forceZero = zeroVec;
    strb.sizeSel   = sizeCode;
    strb.useBcast  = bcast && (sizeCode != SIZE_16);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/lfs_datapath.sv
module lfs_datapath
  import lfs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [VEC_W-1:0] dstIn,
  input  logic [VEC_W-1:0] srcIn,
  input  logic [VEC_W-1:0] cntIn,
  output logic [VEC_W-1:0] dstOut
);

  logic [VEC_W-1:0] resBySize [NUM_SIZES];
  logic             unusedCntBits;

  assign unusedCntBits = ^cntIn;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = CHUNK_W << s;
    localparam int NL = VEC_W / LW;
    localparam int AW = $clog2(LW);
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [AW-1:0] amt;
      assign amt = strb.useBcast ? cntIn[AW-1:0] : cntIn[j*LW +: AW];
      lfs_lane_shift #(.LANE_W(LW)) u_shift (
        .hiIn (srcIn[j*LW +: LW]),
        .loIn (dstIn[j*LW +: LW]),
        .amt  (amt),
        .res  (resBySize[s][j*LW +: LW])
      );
    end
  end

  logic [VEC_W-1:0] shiftSel;
  logic [VEC_W-1:0] nextDst;

  always_comb begin
    case (strb.sizeSel)
      SIZE_16: shiftSel = resBySize[0];
      SIZE_32: shiftSel = resBySize[1];
      default: shiftSel = resBySize[2];
    endcase
  end

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_merge
    always_comb begin
      if (!strb.inRange[c])
        nextDst[c*CHUNK_W +: CHUNK_W] = '0;
      else if (strb.takeShift[c])
        nextDst[c*CHUNK_W +: CHUNK_W] = shiftSel[c*CHUNK_W +: CHUNK_W];
      else if (strb.forceZero[c])
        nextDst[c*CHUNK_W +: CHUNK_W] = '0;
      else
        nextDst[c*CHUNK_W +: CHUNK_W] = dstIn[c*CHUNK_W +: CHUNK_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dstOut <= '0;
    else if (strb.load) dstOut <= nextDst;
  end

endmodule

// File: rtl/lane_funnel_shifter.sv
module lane_funnel_shifter
  import lfs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [1:0]        elemSel,
  input  logic [1:0]        lenSel,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic              bcast,
  input  logic [MASK_W-1:0] maskIn,
  input  logic [VEC_W-1:0]  dstIn,
  input  logic [VEC_W-1:0]  srcIn,
  input  logic [VEC_W-1:0]  cntIn,
  output logic              validOut,
  output logic [VEC_W-1:0]  dstOut
);

  strobe_t strb;

  lfs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .elemSel  (elemSel),
    .lenSel   (lenSel),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .bcast    (bcast),
    .maskIn   (maskIn),
    .strb     (strb),
    .validOut (validOut)
  );

  lfs_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dstIn  (dstIn),
    .srcIn  (srcIn),
    .cntIn  (cntIn),
    .dstOut (dstOut)
  );

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker (
  input logic         clk,
  input logic         rstN,
  input logic         validIn,
  input logic [1:0]   elemSel,
  input logic [1:0]   lenSel,
  input logic         maskEn,
  input logic         zeroMode,
  input logic         bcast,
  input logic [31:0]  maskIn,
  input logic [511:0] dstIn,
  input logic [511:0] srcIn,
  input logic [511:0] cntIn,
  input logic         validOut,
  input logic [511:0] dstOut
);

  p_valid_lag_r11: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(dstOut));

  p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && lenSel == 2'd0) |=> (dstOut[511:128] == '0));

  p_zero_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && maskEn && zeroMode && !maskIn[0]) |=> (dstOut[15:0] == 16'h0));

  p_merge_lane_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && maskEn && !zeroMode && !maskIn[0])
      |=> (dstOut[15:0] == $past(dstIn[15:0])));

  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && elemSel == 2'd0 && !maskEn && cntIn[3:0] == 4'h0)
      |=> (dstOut[15:0] == $past(dstIn[15:0])));

  p_bcast_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && elemSel == 2'd0 && bcast && !maskEn && cntIn[19:16] == 4'h0)
      |=> (dstOut[31:16] == $past(dstIn[31:16])));

endmodule

bind lane_funnel_shifter lfs_checker u_chk (.*);

// File: tb/lane_funnel_shifter_bench.sv
`timescale 1ns/1ps
module lane_funnel_shifter_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [1:0]   elemSel = '0;
  logic [1:0]   lenSel = '0;
  logic         maskEn = 1'b0;
  logic         zeroMode = 1'b0;
  logic         bcast = 1'b0;
  logic [31:0]  maskIn = '0;
  logic [511:0] dstIn = '0;
  logic [511:0] srcIn = '0;
  logic [511:0] cntIn = '0;
  logic         validOut;
  logic [511:0] dstOut;

  int    tests = 0;
  int    fails = 0;
  bit    running = 1'b0;
  string curReq = "R12";

  logic [511:0] expOut = '0;
  logic         expV = 1'b0;

  always #2.5 clk = ~clk;

  lane_funnel_shifter u_lane_funnel_shifter (.*);

  function automatic logic [511:0] refModel(
      input logic [511:0] d, s, c, input logic [31:0] m,
      input logic me, zm, bc, input logic [1:0] es, vl);
    logic [511:0] r;
    int w, vb, nl, amt;
    logic [127:0] t;
    r  = '0;
    w  = (es == 0) ? 16 : (es == 1) ? 32 : 64;
    vb = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
    nl = vb / w;
    for (int j = 0; j < nl; j++) begin
      amt = 0;
      for (int b = 0; b < 6; b++)
        if ((1 << b) < w)
          amt += (bc && w != 16) ? (c[b] << b) : (c[j*w + b] << b);
      t = '0;
      for (int b = 0; b < w; b++) begin
        t[b]     = d[j*w + b];
        t[w + b] = s[j*w + b];
      end
      t = t >> amt;
      for (int b = 0; b < w; b++) begin
        if (!me || m[j])  r[j*w + b] = t[b];
        else if (zm)      r[j*w + b] = 1'b0;
        else              r[j*w + b] = d[j*w + b];
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expOut <= '0;
      expV   <= 1'b0;
    end else begin
      expV <= validIn;
      if (validIn)
        expOut <= refModel(dstIn, srcIn, cntIn, maskIn, maskEn, zeroMode,
                           bcast, elemSel, lenSel);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      tests++;
      if (dstOut !== expOut || validOut !== expV) begin
        fails++;
        $display("FAIL %s: actual valid=%b out=%h expected valid=%b out=%h",
                 curReq, validOut, dstOut, expV, expOut);
      end
    end
  end

  task automatic check16(input string req, input logic [15:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check512(input string req, input logic [511:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  task automatic drive(input logic [511:0] d, s, c, input logic [31:0] m,
                       input logic me, zm, bc, input logic [1:0] es, vl,
                       input string req);
    @(negedge clk);
    curReq = req;
    dstIn = d; srcIn = s; cntIn = c; maskIn = m;
    maskEn = me; zeroMode = zm; bcast = bc; elemSel = es; lenSel = vl;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R11: watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [511:0] d, s, c;
    // R12: reset state
    repeat (3) @(negedge clk);
    check512("R12", dstOut, '0);
    check16("R12", {15'b0, validOut}, 16'h0);
    rstN = 1'b1;
    running = 1'b1;

    // R1: 16-bit lane funnel by 4
    d = '0; s = '0; c = '0;
    d[15:0] = 16'h1234; s[15:0] = 16'hABCD; c[15:0] = 16'd4;
    drive(d, s, c, '0, 0, 0, 0, 2'd0, 2'd2, "R1");
    check16("R1", dstOut[15:0], 16'hD123);

    // R2 / R10: count 31 masked to 15 (width minus one)
    c[15:0] = 16'd31;
    drive(d, s, c, '0, 0, 0, 0, 2'd0, 2'd2, "R2");
    check16("R2 R10", dstOut[15:0], 16'h579A);

    // R10: count 16 masks to zero -> destination unchanged
    c[15:0] = 16'd16;
    drive(d, s, c, '0, 0, 0, 0, 2'd0, 2'd2, "R10");
    check16("R10", dstOut[15:0], 16'h1234);

    // R7: broadcast count 8 on 32-bit lanes, lane 1 own count zero
    d = '0; s = '0; c = '0;
    d[63:32] = 32'h11223344; s[63:32] = 32'hAABBCCDD; c[31:0] = 32'd8;
    drive(d, s, c, '0, 0, 0, 1, 2'd1, 2'd2, "R7");
    check512("R7", {480'b0, dstOut[63:32]}, {480'b0, 32'hDD112233});

    // R8: broadcast ignored for 16-bit lanes
    d = '0; s = '0; c = '0;
    d[31:16] = 16'h5A5A; s[31:16] = 16'hFFFF; c[15:0] = 16'd4;
    drive(d, s, c, '0, 0, 0, 1, 2'd0, 2'd2, "R8");
    check16("R8", dstOut[31:16], 16'h5A5A);

    // R9: all-ones mask on 128-bit vector with zeroing of lanes 0-1 only
    d = rnd512(); s = rnd512(); c = rnd512();
    drive(d, s, c, 32'hFFFF_FFFC, 1, 1, 0, 2'd2, 2'd0, "R9");
    check512("R9", dstOut, '0);
    drive(d, s, c, 32'hFFFF_FFFF, 1, 0, 0, 2'd2, 2'd0, "R9");
    check512("R9 R3", dstOut[511:128], '0);

    // R5 / R6: zero and merge on lane 0
    d = rnd512(); s = rnd512(); c = rnd512();
    drive(d, s, c, 32'hFFFF_FFFE, 1, 1, 0, 2'd1, 2'd2, "R5");
    check16("R5", dstOut[15:0], 16'h0);
    drive(d, s, c, 32'hFFFF_FFFE, 1, 0, 0, 2'd1, 2'd2, "R6");
    check16("R6", dstOut[15:0], d[15:0]);

    // sweep of sizes, lengths and masking modes with random data
    for (int es = 0; es < 4; es++) begin
      for (int vl = 0; vl < 4; vl++) begin
        for (int mode = 0; mode < 4; mode++) begin
          string tag;
          tag = (mode == 0) ? "R4" : (mode == 1) ? "R6" :
                (mode == 2) ? "R5" : "R7";
          if (vl < 2) tag = "R3";
          drive(rnd512(), rnd512(), rnd512(), $urandom(),
                mode == 1 || mode == 2, mode == 2, mode == 3,
                2'(es), 2'(vl), tag);
          // R11: idle gap, output must hold
          curReq = "R11";
          repeat ($urandom_range(0, 2)) @(negedge clk);
        end
      end
    end

    // R11: back-to-back operations
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      curReq = "R11";
      dstIn = rnd512(); srcIn = rnd512(); cntIn = rnd512();
      maskIn = $urandom(); maskEn = 1'($urandom()); zeroMode = 1'($urandom());
      bcast = 1'($urandom()); elemSel = 2'($urandom()); lenSel = 2'($urandom());
      validIn = 1'b1;
    end
    @(negedge clk);
    validIn = 1'b0;
    repeat (3) @(negedge clk);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule